// File: doc/BRIEF.md
# Protected Frame Transmitter

This block turns a wide set of registered local signals into one protected link codeword at a time. It is the sending half of a symmetric data pump: each side copies its own register set across the link, and the two directions are independent. One payload bit does not come from the local signals. It carries a feedback flag that tells the far end the local receiver saw a bad frame. The block appends a 16-bit CRC to the payload. It then wraps payload and CRC in a single-error-correct, double-error-detect Hamming code, giving a 128-bit codeword that goes to a serializer over a valid/ready handshake.

When the far end asks for a repeat, the block resends the codeword it last handed over instead of sampling fresh signals. A repeat request that arrives while a frame is still waiting for the serializer is remembered and honoured at the next hand-over. The output register is the only copy of the frame, so the same storage both presents the frame and holds it for replay.

Top module: `lnk_frame_tx`

## Requirements
- R1: While reset is asserted, `frm_valid_o` is low and `frm_data_o` is all zeros.
- R2: On the first clock edge after reset is released, a fresh frame is loaded and `frm_valid_o` goes high. From then on `frm_valid_o` stays high.
- R3: While `frm_valid_o` is high and `frm_ready_i` is low, `frm_data_o` does not change, even if the payload inputs change.
- R4: At an acceptance edge (valid and ready both high) with no repeat pending, the next frame is built from `pay_i` as sampled at that same edge and is shown from the following cycle.
- R5: The CRC uses polynomial 0x1021 and starts at 0xFFFF. It takes the 104 effective payload bits one per step, starting with bit 103, with no final inversion.
- R6: The 120-bit data word is {payload[103:0], crc[15:0]}, with the CRC in data bits 15:0. Data bit k goes to the k-th codeword position in ascending order among positions 1..127 that are not powers of two. The check bit at position 2^j (j = 0..6) makes the XOR of the indices of all set bits in 1..127 equal to zero. Bit 0 makes the parity of all 128 bits even.
- R7: Payload bit 103 of a fresh frame is not taken from `pay_i[103]`. It is 1 when `rx_err_i` was high at any edge since the last fresh frame was built, including the building edge itself, and 0 otherwise. Building a fresh frame clears the remembered error.
- R8: If `rpt_req_i` is high at an acceptance edge, the next frame is bit-identical to the frame just accepted.
- R9: If `rpt_req_i` is high at an edge without acceptance, the request is remembered. The next acceptance then replays the accepted frame, and the acceptance after that builds a fresh frame.
- R10: A replayed frame keeps its original flag bit. An `rx_err_i` seen during or before a replay stays pending and sets bit 103 of the next fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pay_i | input | 104 | Local registered signals. Bit 103 is replaced by the feedback flag |
| rx_err_i | input | 1 | Local receiver reports a bad incoming frame |
| rpt_req_i | input | 1 | Far end asks for the last frame again |
| frm_valid_o | output | 1 | A codeword is presented |
| frm_ready_i | input | 1 | Serializer takes the codeword at this edge |
| frm_data_o | output | 128 | Protected codeword, bit index equals code position |

## Verification
The bench targets the hand-over edge. A design that sampled the payload one cycle late, or let the frame drift while the serializer stalls, would show a codeword built from the wrong payload. Repeat requests are tested both at the acceptance edge and earlier during a stall. A design that dropped a latched request would send fresh data, and one that failed to clear it would replay twice. The feedback flag is tested across a replay: a design that rewrote the replayed frame, or lost the pending error, would send the wrong bit 103. The codeword itself is compared against an independent bit-serial CRC and a syndrome-based encoder, so any misplaced data or check bit shows up.

// File: rtl/lnk_frame_pkg.sv
package lnk_frame_pkg;
    localparam int PAY_W    = 104;
    localparam int CRC_W    = 16;
    localparam int CODE_W   = 128;
    localparam int CHK_W    = 7;
    localparam int FLAG_IDX = 103;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef struct packed {
        logic              valid;
        logic              rpt_pend;
        logic              err_pend;
        logic [CODE_W-1:0] frame;
    } tx_state_t;
endpackage

// File: rtl/lnk_crc_gen.sv
module lnk_crc_gen #(
    parameter int          DATA_W = 104,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] SEED   = 16'hFFFF
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // Bit-serial recurrence unrolled into one combinational cone, MSB first.
    always_comb begin
        acc = SEED[CRC_W-1:0];
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data_i[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY[CRC_W-1:0];
        end
        crc_o = acc;
    end
endmodule

// File: rtl/lnk_secded_enc.sv
module lnk_secded_enc #(
    parameter int DATA_W = 120,
    parameter int CODE_W = 128,
    parameter int CHK_W  = 7
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] cover_mask(input int j);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int p = 1; p < CODE_W; p++) m[p] = ((p >> j) & 1) == 1;
        return m;
    endfunction

    logic [CODE_W-1:0] body;
    logic [CHK_W-1:0]  chk;

    // Scatter data bits over the non-power-of-two positions.
    always_comb begin
        int k;
        k    = 0;
        body = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                body[p] = data_i[k];
                k++;
            end
        end
    end

    // One parity tree per check position.
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [CODE_W-1:0] MASK = cover_mask(j);
        assign chk[j] = ^(body & MASK);
    end

    always_comb begin
        code_o = body;
        for (int j = 0; j < CHK_W; j++) code_o[1 << j] = chk[j];
        code_o[0] = ^code_o[CODE_W-1:1];
    end
endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx
    import lnk_frame_pkg::*;
#(
    parameter int PAYLOAD_W = PAY_W,
    parameter int CHECK_W   = CRC_W,
    parameter int FRAME_W   = CODE_W,
    parameter int HAM_W     = CHK_W,
    parameter int FLAG_BIT  = FLAG_IDX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAYLOAD_W-1:0] pay_i,
    input  logic                 rx_err_i,
    input  logic                 rpt_req_i,
    output logic                 frm_valid_o,
    input  logic                 frm_ready_i,
    output logic [FRAME_W-1:0]   frm_data_o
);
    localparam int DATA_W = PAYLOAD_W + CHECK_W;

    logic [PAYLOAD_W-1:0] pay_eff;
    logic [CHECK_W-1:0]   crc;
    logic [FRAME_W-1:0]   fresh_cw;
    logic                 flag_now;
    logic                 accept;
    logic                 want_rpt;

    typedef struct packed {
        logic               valid;
        logic               rpt_pend;
        logic               err_pend;
        logic [FRAME_W-1:0] frame;
    } st_t;

    st_t st_d, st_q;

    assign flag_now = st_q.err_pend | rx_err_i;

    always_comb begin
        pay_eff           = pay_i;
        pay_eff[FLAG_BIT] = flag_now;
    end

    lnk_crc_gen #(
        .DATA_W (PAYLOAD_W),
        .CRC_W  (CHECK_W),
        .POLY   (CRC_POLY),
        .SEED   (CRC_SEED)
    ) crc_i (
        .data_i (pay_eff),
        .crc_o  (crc)
    );

    lnk_secded_enc #(
        .DATA_W (DATA_W),
        .CODE_W (FRAME_W),
        .CHK_W  (HAM_W)
    ) enc_i (
        .data_i ({pay_eff, crc}),
        .code_o (fresh_cw)
    );

    assign accept   = st_q.valid & frm_ready_i;
    assign want_rpt = st_q.rpt_pend | rpt_req_i;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            // First slot after reset: nothing to replay yet.
            st_d.valid    = 1'b1;
            st_d.frame    = fresh_cw;
            st_d.err_pend = 1'b0;
            st_d.rpt_pend = want_rpt;
        end else if (accept && want_rpt) begin
            // The register already holds the frame just taken: keep it.
            st_d.rpt_pend = 1'b0;
            st_d.err_pend = flag_now;
        end else if (accept) begin
            st_d.frame    = fresh_cw;
            st_d.err_pend = 1'b0;
        end else begin
            st_d.rpt_pend = want_rpt;
            st_d.err_pend = flag_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_valid_o = st_q.valid;
    assign frm_data_o  = st_q.frame;
endmodule

// File: rtl/lnk_frame_tx_chk.sv
module lnk_frame_tx_chk #(
    parameter int FRAME_W = 128,
    parameter int HAM_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rpt_req_i,
    input logic               frm_valid_o,
    input logic               frm_ready_i,
    input logic [FRAME_W-1:0] frm_data_o
);
    function automatic logic [HAM_W-1:0] syndrome(input logic [FRAME_W-1:0] cw);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p < FRAME_W; p++) if (cw[p]) s = s ^ p[HAM_W-1:0];
        return s;
    endfunction

    logic req_seen_q;
    logic take;
    assign take = frm_valid_o & frm_ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n)    req_seen_q <= 1'b0;
        else if (take) req_seen_q <= 1'b0;
        else           req_seen_q <= req_seen_q | rpt_req_i;
    end

    // R1: idle while reset holds
    always_ff @(posedge clk) begin
        if (!rst_n) assert_reset_idle_R1: assert (!frm_valid_o || $time == 0);
    end

    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |=> frm_valid_o);

    assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && !frm_ready_i) |=> $stable(frm_data_o));

    assert_code_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |-> (syndrome(frm_data_o) == '0 && ^frm_data_o == 1'b0));

    assert_replay_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rpt_req_i) |=> $stable(frm_data_o));

    assert_replay_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_seen_q) |=> $stable(frm_data_o));
endmodule

bind lnk_frame_tx lnk_frame_tx_chk #(
    .FRAME_W (FRAME_W),
    .HAM_W   (HAM_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rpt_req_i   (rpt_req_i),
    .frm_valid_o (frm_valid_o),
    .frm_ready_i (frm_ready_i),
    .frm_data_o  (frm_data_o)
);

// File: tb/lnk_frame_tx_tb_top.sv
module lnk_frame_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [103:0] pay;
    logic         rx_err;
    logic         rpt_req;
    logic         ready;
    logic         valid;
    logic [127:0] data;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lnk_frame_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pay_i       (pay),
        .rx_err_i    (rx_err),
        .rpt_req_i   (rpt_req),
        .frm_valid_o (valid),
        .frm_ready_i (ready),
        .frm_data_o  (data)
    );

    // Independent model: serial CRC, then a syndrome-driven encoder.
    function automatic logic [127:0] ref_frame(input logic [103:0] p, input logic flag);
        logic [103:0] q;
        logic [15:0]  c;
        logic         fb;
        logic [119:0] w;
        logic [127:0] cw;
        logic [6:0]   syn;
        int           k;
        q = p;
        q[103] = flag;
        c = 16'hFFFF;
        for (int i = 103; i >= 0; i--) begin
            fb = c[15] ^ q[i];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        w   = {q, c};
        cw  = '0;
        k   = 0;
        for (int pos = 1; pos < 128; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[pos] = w[k];
                k++;
            end
        end
        syn = '0;
        for (int pos = 1; pos < 128; pos++) if (cw[pos]) syn = syn ^ pos[6:0];
        for (int j = 0; j < 7; j++) cw[1 << j] = syn[j];
        cw[0] = ^cw[127:1];
        return cw;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_and_first;
        logic [103:0] a;
        a = {8'h5A, 32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C};
        rst_n = 1'b0; pay = a; rx_err = 0; rpt_req = 0; ready = 0;
        step; step;
        check(valid == 1'b0, "R1 valid in reset", {127'd0, valid}, 128'd0);
        check(data == '0, "R1 data in reset", data, 128'd0);
        rst_n = 1'b1;
        step;
        check(valid == 1'b1, "R2 valid after reset", {127'd0, valid}, 128'd1);
        check(data == ref_frame(a, 1'b0), "R5 R6 first frame", data, ref_frame(a, 1'b0));
    endtask

    task automatic t_stall;
        logic [127:0] held;
        held = data;
        pay  = {8'hFF, 32'hDEADBEEF, 32'hCAFEF00D, 32'h12345678};
        step; step; step;
        check(data == held, "R3 stall hold", data, held);
        check(valid == 1'b1, "R2 valid stays", {127'd0, valid}, 128'd1);
    endtask

    task automatic t_accept;
        logic [103:0] b;
        b = {8'h00, 32'h00000001, 32'h80000000, 32'hA5A5A5A5};
        pay = b; ready = 1;
        step;
        ready = 0;
        pay = '1;
        check(data == ref_frame(b, 1'b0), "R4 fresh at accept", data, ref_frame(b, 1'b0));
    endtask

    task automatic t_flag;
        logic [103:0] c;
        logic [103:0] d;
        c = {8'h11, 32'h22223333, 32'h44445555, 32'h66667777};
        d = {8'hC3, 32'h0, 32'hFFFFFFFF, 32'h0};
        rx_err = 1; step; rx_err = 0;
        pay = c; step;
        ready = 1; step; ready = 0;
        check(data == ref_frame(c, 1'b1), "R7 flag set", data, ref_frame(c, 1'b1));
        pay = d; ready = 1; step; ready = 0;
        check(data == ref_frame(d, 1'b0), "R7 flag cleared, pay bit ignored", data, ref_frame(d, 1'b0));
    endtask

    task automatic t_repeat_now;
        logic [127:0] prev;
        logic [103:0] e;
        e = {8'h77, 32'h13579BDF, 32'h2468ACE0, 32'h0BADCAFE};
        prev = data;
        pay = e; ready = 1; rpt_req = 1;
        step;
        ready = 0; rpt_req = 0;
        check(data == prev, "R8 immediate replay", data, prev);
        ready = 1; step; ready = 0;
        check(data == ref_frame(e, 1'b0), "R9 single replay then fresh", data, ref_frame(e, 1'b0));
    endtask

    task automatic t_repeat_late;
        logic [127:0] prev;
        logic [103:0] f;
        f = {8'h3C, 32'hFEDCBA98, 32'h76543210, 32'h55AA55AA};
        prev = data;
        rpt_req = 1; step; rpt_req = 0;
        step;
        pay = f; ready = 1; step; ready = 0;
        check(data == prev, "R9 latched replay", data, prev);
        ready = 1; step; ready = 0;
        check(data == ref_frame(f, 1'b0), "R9 fresh after latched", data, ref_frame(f, 1'b0));
    endtask

    task automatic t_replay_flag;
        logic [127:0] prev;
        logic [103:0] g;
        g = {8'h01, 32'h10203040, 32'h50607080, 32'h90A0B0C0};
        prev = data;
        pay = g; rx_err = 1; rpt_req = 1; ready = 1;
        step;
        rx_err = 0; rpt_req = 0; ready = 0;
        check(data == prev, "R10 replay keeps flag", data, prev);
        ready = 1; step; ready = 0;
        check(data == ref_frame(g, 1'b1), "R10 pending flag on fresh", data, ref_frame(g, 1'b1));
    endtask

    task automatic t_stream;
        logic [103:0] p;
        ready = 1;
        for (int i = 0; i < 8; i++) begin
            p = {i[7:0], 32'h9E3779B9 * (i + 1), ~(32'h7F4A7C15 * i), 32'h1 << (i * 4)};
            pay = p;
            step;
            check(data == ref_frame(p, 1'b0), "R4 R6 streaming", data, ref_frame(p, 1'b0));
        end
        ready = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_and_first;
        t_stall;
        t_accept;
        t_flag;
        t_repeat_now;
        t_repeat_late;
        t_replay_flag;
        t_stream;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule